// File: doc/BRIEF.md
# Display Mode Register Window

This block is the control register window of a simple linear framebuffer display device. It holds 128 bytes of byte-addressable storage. The host may read or write 1, 2, 4 or 8 bytes at any byte offset. The low twelve bytes hold the display geometry fields in little-endian order. The remaining bytes are plain read/write storage with no function.

Every accepted write triggers one evaluation cycle. In that cycle the block decides between a legacy text mode and a linear graphics mode, based on whether width and height are both zero or both non-zero. In linear mode it compares the programmed geometry with the geometry last handed to the display side. When they differ, it raises a one-cycle resize request carrying the new width and height.

Host accesses arrive on a valid/ready request channel. The block never applies back-pressure: `req_ready` is held high, and a request is taken on every clock edge where `req_valid` is high. Read data comes back on a response strobe exactly one cycle later. The response has no ready signal, so the host must always be able to take it.

Top module: `dispmode_regwin`

## Requirements
- R1: An access whose offset plus size exceeds 128 is dropped on write (no byte changes) and returns zero on read; an access ending exactly at byte 128 is legal.
- R2: Only sizes 1, 2, 4 and 8 are legal; a write of any other size changes nothing and a read of any other size returns zero.
- R3: The fields are little-endian: the 32-bit framebuffer size is at bytes 0-3, width at 4-5, height at 6-7, depth at 8-9 and refresh rate at 10-11; bytes 12-127 read back what was written.
- R4: After reset, framebuffer size is 0x0100_0000, width is 1024, height is 768, depth is 32, refresh rate is 0, and every other byte is zero.
- R5: A write stores the low `size` bytes of `req_wdata` at the offset, lowest byte first; a read returns the addressed bytes, lowest byte in bits 7:0, zero-extended to 64 bits.
- R6: `req_ready` is always high. `rsp_valid` is high for exactly the one cycle after an accepted read, and never after a write.
- R7: On the evaluation cycle after a write, if the mode is linear and width and height are both zero, `legacy_mode` becomes 1, the latched geometry on `resize_width`/`resize_height` becomes 0x0, and no resize is requested.
- R8: On the evaluation cycle after a write, if the mode is legacy and width and height are both non-zero, `legacy_mode` becomes 0.
- R9: On the evaluation cycle after a write, if the resulting mode is linear and the register geometry differs from the latched geometry, `resize_pulse` is high for one cycle with the new width and height, and those values become the latched geometry; if they are equal, no pulse occurs.
- R10: After reset `legacy_mode` is 0, the latched geometry is 1024x768 and no resize pulse occurs; a write leaving exactly one of width or height zero does not change the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Request accepted (always 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_offset | input | 8 | Byte offset of the access |
| req_size | input | 4 | Access size in bytes |
| req_wdata | input | 64 | Write data, low bytes used |
| rsp_valid | output | 1 | Read data valid, one cycle after the read |
| rsp_rdata | output | 64 | Read data, zero-extended |
| legacy_mode | output | 1 | 1 = legacy text mode, 0 = linear graphics mode |
| resize_pulse | output | 1 | One-cycle resize request |
| resize_width | output | 16 | Latched display width |
| resize_height | output | 16 | Latched display height |

## Verification
The assertions assume reset is asserted before the first request and that request fields are stable whenever `req_valid` is high. They place no limit on the offset or size values, because out-of-range and odd-size accesses are part of the checked behaviour.

The bench changes inputs only on the falling edge and sends one request at a time. Each request is followed by at least one idle cycle, so every evaluation cycle and read response can be attributed to a single access. It deliberately sends offsets past the window end, a size of zero, a size of three, and writes whose upper data bytes are non-zero. This exercises the drop and zero-return paths that the assertions watch.

// File: rtl/dmw_pkg.sv
package dmw_pkg;
  localparam int unsigned SZ_W       = 4;
  localparam int unsigned GEOM_W     = 16;
  localparam int unsigned FLD_WIDTH  = 4;
  localparam int unsigned FLD_HEIGHT = 6;

  function automatic logic size_legal(input logic [SZ_W-1:0] sz);
    return (sz == SZ_W'(1)) || (sz == SZ_W'(2)) ||
           (sz == SZ_W'(4)) || (sz == SZ_W'(8));
  endfunction
endpackage

// File: rtl/dmw_regfile.sv
module dmw_regfile
  import dmw_pkg::*;
#(
  parameter int unsigned       WIN_BYTES  = 128,
  parameter int unsigned       BUS_BYTES  = 8,
  parameter int unsigned       OFS_W      = 8,
  parameter logic [31:0]       RST_FBSIZE = 32'h0100_0000,
  parameter logic [GEOM_W-1:0] RST_WIDTH  = 16'd1024,
  parameter logic [GEOM_W-1:0] RST_HEIGHT = 16'd768,
  parameter logic [GEOM_W-1:0] RST_DEPTH  = 16'd32,
  parameter logic [GEOM_W-1:0] RST_RATE   = 16'd0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic                   rd_en,
  input  logic [OFS_W-1:0]       ofs,
  input  logic [SZ_W-1:0]        sz,
  input  logic [BUS_BYTES*8-1:0] wdata,
  output logic                   rd_valid,
  output logic [BUS_BYTES*8-1:0] rd_data,
  output logic [GEOM_W-1:0]      geom_w,
  output logic [GEOM_W-1:0]      geom_h
);
  localparam int unsigned DATA_W    = BUS_BYTES * 8;
  localparam int unsigned IDX_W     = $clog2(WIN_BYTES);
  localparam int unsigned BSEL_W    = $clog2(BUS_BYTES);
  localparam int unsigned SPAN_W    = OFS_W + 1;
  localparam int unsigned IMG_BYTES = 12;
  localparam logic [IMG_BYTES*8-1:0] RST_IMG =
    {RST_RATE, RST_DEPTH, RST_HEIGHT, RST_WIDTH, RST_FBSIZE};

  function automatic logic [7:0] init_byte(input int unsigned i);
    if (i < IMG_BYTES) return RST_IMG[i*8 +: 8];
    return 8'h00;
  endfunction

  logic [SPAN_W-1:0]      span;
  logic                   sz_ok;
  logic                   span_ok;
  logic                   legal;
  logic [7:0]             byte_w [WIN_BYTES];
  logic [WIN_BYTES*8-1:0] store_flat;
  logic [DATA_W-1:0]      rd_next;

  assign span    = {1'b0, ofs} + SPAN_W'(sz);
  assign sz_ok   = size_legal(sz);
  assign span_ok = (span <= SPAN_W'(WIN_BYTES));
  assign legal   = sz_ok && span_ok;

  for (genvar b = 0; b < WIN_BYTES; b++) begin : g_byte
    logic [SPAN_W-1:0] rel;
    logic              hit;
    logic [7:0]        q;
    assign rel = SPAN_W'(b) - {1'b0, ofs};
    assign hit = wr_en && legal && (SPAN_W'(b) >= {1'b0, ofs}) && (rel < SPAN_W'(sz));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= init_byte(b);
      else if (hit) q <= wdata[rel[BSEL_W-1:0]*8 +: 8];
    end
    assign byte_w[b]           = q;
    assign store_flat[b*8 +: 8] = q;
  end

  always_comb begin
    rd_next = '0;
    for (int k = 0; k < BUS_BYTES; k++) begin
      if (legal && (SPAN_W'(k) < SPAN_W'(sz)))
        rd_next[k*8 +: 8] = byte_w[ofs[IDX_W-1:0] + IDX_W'(k)];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_next;
    end
  end

  assign geom_w = {byte_w[FLD_WIDTH + 1], byte_w[FLD_WIDTH]};
  assign geom_h = {byte_w[FLD_HEIGHT + 1], byte_w[FLD_HEIGHT]};

  a_r1_oob_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !span_ok) |=> $stable(store_flat));
  a_r2_bad_size_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !sz_ok) |=> $stable(store_flat));
  a_r1_bad_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !legal) |=> (rd_data == '0));
  a_r6_rsp_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(rd_en));
endmodule

// File: rtl/dmw_mode_ctl.sv
module dmw_mode_ctl
  import dmw_pkg::*;
#(
  parameter logic [GEOM_W-1:0] RST_WIDTH  = 16'd1024,
  parameter logic [GEOM_W-1:0] RST_HEIGHT = 16'd768
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_done,
  input  logic [GEOM_W-1:0] geom_w,
  input  logic [GEOM_W-1:0] geom_h,
  output logic              legacy,
  output logic              resize_pulse,
  output logic [GEOM_W-1:0] lat_w,
  output logic [GEOM_W-1:0] lat_h
);
  logic both_zero;
  logic both_set;
  logic nxt_legacy;

  assign both_zero = (geom_w == '0) && (geom_h == '0);
  assign both_set  = (geom_w != '0) && (geom_h != '0);

  always_comb begin
    nxt_legacy = legacy;
    if (!legacy && both_zero)    nxt_legacy = 1'b1;
    else if (legacy && both_set) nxt_legacy = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      legacy       <= 1'b0;
      resize_pulse <= 1'b0;
      lat_w        <= RST_WIDTH;
      lat_h        <= RST_HEIGHT;
    end else begin
      resize_pulse <= 1'b0;
      if (wr_done) begin
        legacy <= nxt_legacy;
        if (nxt_legacy) begin
          if (!legacy) begin
            lat_w <= '0;
            lat_h <= '0;
          end
        end else if ((lat_w != geom_w) || (lat_h != geom_h)) begin
          resize_pulse <= 1'b1;
          lat_w        <= geom_w;
          lat_h        <= geom_h;
        end
      end
    end
  end

  a_r7_mode_moves_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(legacy) |-> $past(wr_done));
  a_r7_enter_clears_latch: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(legacy) |-> (lat_w == '0 && lat_h == '0 && !resize_pulse));
  a_r8_exit_needs_geometry: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(legacy) |-> $past(geom_w != '0 && geom_h != '0));
  a_r9_pulse_linear_only: assert property (@(posedge clk) disable iff (!rst_n)
    resize_pulse |-> (!legacy && $past(wr_done)));
endmodule

// File: rtl/dispmode_regwin.sv
module dispmode_regwin
  import dmw_pkg::*;
#(
  parameter int unsigned       WIN_BYTES  = 128,
  parameter int unsigned       BUS_BYTES  = 8,
  parameter int unsigned       OFS_W      = 8,
  parameter logic [31:0]       RST_FBSIZE = 32'h0100_0000,
  parameter logic [GEOM_W-1:0] RST_WIDTH  = 16'd1024,
  parameter logic [GEOM_W-1:0] RST_HEIGHT = 16'd768,
  parameter logic [GEOM_W-1:0] RST_DEPTH  = 16'd32,
  parameter logic [GEOM_W-1:0] RST_RATE   = 16'd0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_write,
  input  logic [OFS_W-1:0]       req_offset,
  input  logic [SZ_W-1:0]        req_size,
  input  logic [BUS_BYTES*8-1:0] req_wdata,
  output logic                   rsp_valid,
  output logic [BUS_BYTES*8-1:0] rsp_rdata,
  output logic                   legacy_mode,
  output logic                   resize_pulse,
  output logic [GEOM_W-1:0]      resize_width,
  output logic [GEOM_W-1:0]      resize_height
);
  logic              fire;
  logic              wr_fire;
  logic              rd_fire;
  logic              wr_done;
  logic [GEOM_W-1:0] geom_w;
  logic [GEOM_W-1:0] geom_h;

  assign req_ready = 1'b1;
  assign fire      = req_valid && req_ready;
  assign wr_fire   = fire && req_write;
  assign rd_fire   = fire && !req_write;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_done <= 1'b0;
    else        wr_done <= wr_fire;
  end

  dmw_regfile #(
    .WIN_BYTES (WIN_BYTES), .BUS_BYTES (BUS_BYTES), .OFS_W (OFS_W),
    .RST_FBSIZE(RST_FBSIZE), .RST_WIDTH (RST_WIDTH), .RST_HEIGHT(RST_HEIGHT),
    .RST_DEPTH (RST_DEPTH),  .RST_RATE  (RST_RATE)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_fire),
    .rd_en   (rd_fire),
    .ofs     (req_offset),
    .sz      (req_size),
    .wdata   (req_wdata),
    .rd_valid(rsp_valid),
    .rd_data (rsp_rdata),
    .geom_w  (geom_w),
    .geom_h  (geom_h)
  );

  dmw_mode_ctl #(
    .RST_WIDTH (RST_WIDTH),
    .RST_HEIGHT(RST_HEIGHT)
  ) u_mode (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_done     (wr_done),
    .geom_w      (geom_w),
    .geom_h      (geom_h),
    .legacy      (legacy_mode),
    .resize_pulse(resize_pulse),
    .lat_w       (resize_width),
    .lat_h       (resize_height)
  );

  a_r6_no_rsp_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !$past(req_write && req_valid));
endmodule

// File: tb/dispmode_regwin_bench.sv
module dispmode_regwin_bench;
  typedef struct packed {
    logic        wr;
    logic [7:0]  ofs;
    logic [3:0]  sz;
    logic [63:0] data;
    logic [63:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 26;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 8'd0,   4'd4, 64'h0, 64'h0000_0000_0100_0000, 4'd4},  // R4 fb size
    '{1'b0, 8'd4,   4'd4, 64'h0, 64'h0000_0000_0300_0400, 4'd4},  // R4 width/height
    '{1'b0, 8'd8,   4'd2, 64'h0, 64'h0000_0000_0000_0020, 4'd4},  // R4 depth
    '{1'b0, 8'd10,  4'd2, 64'h0, 64'h0,                   4'd4},  // R4 rate
    '{1'b0, 8'd0,   4'd8, 64'h0, 64'h0300_0400_0100_0000, 4'd3},  // R3 layout
    '{1'b1, 8'd12,  4'd8, 64'h1122_3344_5566_7788, 64'h0, 4'd5},  // R5
    '{1'b0, 8'd12,  4'd8, 64'h0, 64'h1122_3344_5566_7788, 4'd5},  // R5
    '{1'b0, 8'd13,  4'd1, 64'h0, 64'h77,                  4'd5},  // R5
    '{1'b0, 8'd14,  4'd2, 64'h0, 64'h5566,                4'd5},  // R5
    '{1'b1, 8'd120, 4'd8, 64'hDEAD_BEEF_CAFE_F00D, 64'h0, 4'd1},  // R1 edge
    '{1'b0, 8'd120, 4'd8, 64'h0, 64'hDEAD_BEEF_CAFE_F00D, 4'd1},  // R1
    '{1'b1, 8'd124, 4'd8, 64'h0, 64'h0,                   4'd1},  // R1 dropped
    '{1'b0, 8'd120, 4'd8, 64'h0, 64'hDEAD_BEEF_CAFE_F00D, 4'd1},  // R1 intact
    '{1'b0, 8'd124, 4'd8, 64'h0, 64'h0,                   4'd1},  // R1 zero
    '{1'b0, 8'd127, 4'd1, 64'h0, 64'hDE,                  4'd1},  // R1 last byte
    '{1'b0, 8'd121, 4'd8, 64'h0, 64'h0,                   4'd1},  // R1 span 129
    '{1'b1, 8'd20,  4'd3, 64'hFF_FFFF, 64'h0,             4'd2},  // R2 size 3
    '{1'b0, 8'd20,  4'd4, 64'h0, 64'h0,                   4'd2},  // R2 untouched
    '{1'b0, 8'd3,   4'd3, 64'h0, 64'h0,                   4'd2},  // R2 read size 3
    '{1'b0, 8'd0,   4'd0, 64'h0, 64'h0,                   4'd2},  // R2 size 0
    '{1'b1, 8'd10,  4'd2, 64'hFFFF_FFFF_FFFF_003C, 64'h0, 4'd5},  // R5 low bytes
    '{1'b0, 8'd10,  4'd4, 64'h0, 64'h7788_003C,           4'd3},  // R3
    '{1'b1, 8'd8,   4'd1, 64'hFFFF_FF10, 64'h0,           4'd3},  // R3 depth
    '{1'b0, 8'd8,   4'd2, 64'h0, 64'h0010,                4'd3},  // R3
    '{1'b1, 8'd200, 4'd1, 64'hFF, 64'h0,                  4'd1},  // R1 far offset
    '{1'b0, 8'd72,  4'd1, 64'h0, 64'h0,                   4'd1}   // R1 no alias
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [7:0]  req_offset = '0;
  logic [3:0]  req_size = '0;
  logic [63:0] req_wdata = '0;
  logic        rsp_valid;
  logic [63:0] rsp_rdata;
  logic        legacy_mode;
  logic        resize_pulse;
  logic [15:0] resize_width;
  logic [15:0] resize_height;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  dispmode_regwin u_dispmode_regwin (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_offset(req_offset), .req_size(req_size),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .legacy_mode(legacy_mode), .resize_pulse(resize_pulse),
    .resize_width(resize_width), .resize_height(resize_height)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Drive at a falling edge, accept at the next rising edge; returns at the following falling edge.
  task automatic access(input logic wr, input logic [7:0] ofs, input logic [3:0] sz,
                        input logic [63:0] data, output logic rv, output logic [63:0] rd);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_offset = ofs; req_size = sz; req_wdata = data;
    @(posedge clk); #1;
    rv = rsp_valid; rd = rsp_rdata;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic geom_write(input logic [7:0] ofs, input logic [3:0] sz, input logic [63:0] data,
                            input logic exp_pulse, input logic [15:0] ew, input logic [15:0] eh,
                            input logic exp_leg, input string req);
    logic rv; logic [63:0] rd;
    access(1'b1, ofs, sz, data, rv, rd);
    @(posedge clk); #1;
    chk(req, "resize_pulse", 64'(resize_pulse), 64'(exp_pulse));
    chk(req, "legacy_mode", 64'(legacy_mode), 64'(exp_leg));
    if (exp_pulse || exp_leg) begin
      chk(req, "resize_width", 64'(resize_width), 64'(ew));
      chk(req, "resize_height", 64'(resize_height), 64'(eh));
    end
    @(posedge clk); #1;
    chk(req, "pulse single cycle", 64'(resize_pulse), 64'h0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    logic rv; logic [63:0] rd;
    do_reset();
    @(posedge clk); #1;
    // R4 / R10 / R6 reset state
    chk("R10", "legacy after reset", 64'(legacy_mode), 64'h0);
    chk("R10", "pulse after reset", 64'(resize_pulse), 64'h0);
    chk("R10", "latched width", 64'(resize_width), 64'd1024);
    chk("R10", "latched height", 64'(resize_height), 64'd768);
    chk("R6", "ready high", 64'(req_ready), 64'h1);
    chk("R6", "no rsp after reset", 64'(rsp_valid), 64'h0);
    for (int c = 0; c < 3; c++) begin
      @(posedge clk); #1;
      chk("R10", "no spurious resize", 64'(resize_pulse), 64'h0);
    end

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d", VEC[i].req);
      access(VEC[i].wr, VEC[i].ofs, VEC[i].sz, VEC[i].data, rv, rd);
      if (VEC[i].wr) begin
        chk("R6", $sformatf("no rsp on write %0d", i), 64'(rv), 64'h0);
      end else begin
        chk("R6", $sformatf("rsp_valid on read %0d", i), 64'(rv), 64'h1);
        chk(tag, $sformatf("read data entry %0d", i), rd, VEC[i].exp);
      end
      @(posedge clk); #1;
      chk("R6", $sformatf("rsp drops entry %0d", i), 64'(rsp_valid), 64'h0);
    end

    do_reset();
    geom_write(8'd4, 4'd2, 64'd800, 1'b1, 16'd800, 16'd768, 1'b0, "R9");
    geom_write(8'd4, 4'd2, 64'd800, 1'b0, 16'd0, 16'd0, 1'b0, "R9");
    geom_write(8'd4, 4'd4, 64'h0, 1'b0, 16'd0, 16'd0, 1'b1, "R7");
    geom_write(8'd4, 4'd2, 64'd640, 1'b0, 16'd0, 16'd0, 1'b1, "R10");
    geom_write(8'd6, 4'd2, 64'd480, 1'b1, 16'd640, 16'd480, 1'b0, "R8");
    geom_write(8'd6, 4'd2, 64'd0, 1'b1, 16'd640, 16'd0, 1'b0, "R10");
    geom_write(8'd4, 4'd2, 64'd0, 1'b0, 16'd0, 16'd0, 1'b1, "R7");
    geom_write(8'd5, 4'd1, 64'h01, 1'b0, 16'd0, 16'd0, 1'b1, "R10");
    geom_write(8'd4, 4'd4, 64'h0258_0320, 1'b1, 16'd800, 16'd600, 1'b0, "R8");
    access(1'b0, 8'd4, 4'd4, 64'h0, rv, rd);
    chk("R3", "geometry readback", rd, 64'h0258_0320);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule